// File: doc/BRIEF.md
# Serial EEPROM Word Reader with Software Pin Override

This block fetches 16-bit words from a small serial EEPROM attached over a four-wire SPI link (clock, active-low select, data out, data in). A host starts a fetch by writing a word address with the start bit set into the request register. The block then polls the device's status register until the device is no longer busy. It sends a read command with the byte address and shifts in two bytes. It places the word in the upper half of the same register and raises a done flag.

A second register lets software drive the SPI pins directly. Software sets a request bit and waits for a grant bit. While the grant is held, the clock, select and data-out pins follow the register bits, and the data-in pin can be read back. The hardware engine and software never own the pins at the same time. A start written while software holds the pins waits until the request is dropped. The device holds 64 words, and a valid image sums to 0xBABA modulo 2^16.

Top module: `spi_word_reader`

## Requirements
- R1: After reset the request register reads 0, bits 7:0 of the pin register read 0 except the live data-in bit 3, select is high (inactive) and the SPI clock is low.
- R2: Writing the request register with bit 0 (start) set clears done (bit 1) in the next cycle and shows start = 1. Start self-clears on the following cycle, when the transaction begins.
- R3: A fetch sends opcode 0x03, then the byte address (twice the word address), then reads two bytes. The first byte is the low byte. The word appears in bits 31:16 with done = 1 and start = 0.
- R4: Before each read the block sends opcode 0x05 and reads one status byte. While status bit 0 is 1 it repeats the poll, so a device busy for N polls sees N+1 polls.
- R5: The engine keeps select high for at least CLK_DIV system cycles before every assertion of select, including between the poll and the read.
- R6: SPI mode 0: the clock idles low and data out never changes at a rising clock edge; the SPI clock period is CLK_DIV system cycles.
- R7: With request (pin register bit 6) set, the engine idle and no start pending, grant (bit 7) reads 1 one cycle later. Clearing request drops grant on the next edge. The engine never asserts select while grant is 1.
- R8: While grant is 1 the clock, select and data-out pins follow bits 0, 1 and 2 (bit 1 = 1 drives select low). Without grant, writes to those bits are ignored and they read 0.
- R9: A start written while grant is 1 stays pending and no transfer happens. It begins after request is cleared and returns the addressed word.
- R10: When start and request arrive in the same cycle with the engine idle, the engine wins. Grant is withheld until the fetch has finished and is then given.
- R11: Writes to the request register while a fetch is in progress are ignored. The address and the returned word belong to the first request.
- R12: Pin register bit 8 reflects the EEPROM-present input and bit 3 reflects the data-in pin at all times.
- R13: Only the low 6 bits of the 14-bit word address field (bits 15:2) are used, so addresses wrap modulo 64. Reading all 64 words of a valid image gives a sum of 0xBABA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Write strobe for the request register |
| req_wdata | input | 32 | Request register write data: start bit 0, word address bits 15:2 |
| req_rdata | output | 32 | Request register: start 0, done 1, address 15:2, word 31:16 |
| bb_wr | input | 1 | Write strobe for the pin register |
| bb_wdata | input | 32 | Pin register write data: clock 0, select 1, data out 2, request 6 |
| bb_rdata | output | 32 | Pin register: pins 2:0, data in 3, request 6, grant 7, present 8 |
| ee_present | input | 1 | High when an EEPROM is attached |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI select, active low |
| spi_mosi | output | 1 | Data to the EEPROM |
| spi_miso | input | 1 | Data from the EEPROM |

## Verification
A start and a pin request can land in the same cycle, and the arbitration must hand the port to exactly one of them. The bench writes both registers on one clock edge while the engine is idle. It then expects start to clear on the next edge, grant to stay low for the whole fetch, the word to match the image, and grant to rise once done is set. The opposite ordering is also provoked: a start arrives while grant is held, and the bench confirms it stays pending with no select activity until request is dropped.

// File: rtl/spi_rd_pkg.sv
// Package: shared opcodes, register field positions and the sequencer state
// type for the serial EEPROM word reader.
package spi_rd_pkg;
    localparam logic [7:0] OP_READ    = 8'h03;  // read data command
    localparam logic [7:0] OP_STATUS  = 8'h05;  // read status command

    // request register field positions
    localparam int REQ_START = 0;
    localparam int REQ_DONE  = 1;
    localparam int REQ_ALO   = 2;
    localparam int REQ_AHI   = 15;
    localparam int REQ_DLO   = 16;

    // pin register field positions
    localparam int PIN_SCK   = 0;
    localparam int PIN_CS    = 1;
    localparam int PIN_MOSI  = 2;
    localparam int PIN_REQ   = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_POLL_CMD,
        S_POLL_STAT,
        S_RD_CMD,
        S_RD_ADDR,
        S_RD_LO,
        S_RD_HI
    } seq_state_e;
endpackage

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Shifts one byte out MSB first and one byte in, in SPI mode 0.
// Assumes: CLK_DIV is even and >= 2; go is only honoured while idle; the
// caller owns chip select. The clock is low whenever the shifter is idle.
module spi_byte_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = $clog2(HALF + 1);

    logic          busy;
    logic          hi_phase;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    sh;
    logic [7:0]    rx;

    // Bit timing: half period low (data set), half period high (data sampled).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            hi_phase <= 1'b0;
            cnt      <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            rx       <= '0;
            sck      <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy     <= 1'b1;
                    hi_phase <= 1'b0;
                    cnt      <= '0;
                    bit_idx  <= '0;
                    sh       <= tx_byte;
                end
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                if (!hi_phase) begin
                    sck      <= 1'b1;
                    rx       <= {rx[6:0], miso};
                    hi_phase <= 1'b1;
                end else begin
                    sck      <= 1'b0;
                    hi_phase <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        sh      <= {sh[6:0], 1'b0};
                    end
                end
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign mosi    = sh[7];
    assign rx_byte = rx;
endmodule

// File: rtl/spi_read_seq.sv
// Module: spi_read_seq
// Runs one word fetch: select gap, status poll (repeated while busy), gap,
// read command, byte address, low byte, high byte.
// Assumes: launch is a one-cycle pulse accepted only in S_IDLE; WORD_AW <= 7
// so the byte address fits one address byte.
module spi_read_seq
    import spi_rd_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int WORD_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [WORD_AW-1:0] word_addr,
    input  logic               sh_done,
    input  logic [7:0]         sh_rx,
    output logic               sh_go,
    output logic [7:0]         sh_tx,
    output logic               cs_act,
    output logic               idle,
    output logic               fin,
    output logic [15:0]        rd_word
);
    localparam int GW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    seq_state_e         state;
    logic [GW-1:0]      gap_cnt;
    logic               again;
    logic [7:0]         lo_byte;
    logic [WORD_AW-1:0] addr_q;
    logic [7:0]         byte_addr;

    // Byte address: word address doubled, zero-extended to one byte.
    always_comb begin
        byte_addr = '0;
        byte_addr[WORD_AW:0] = {addr_q, 1'b0};
    end

    // Transaction state machine; go and fin are single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            gap_cnt <= '0;
            again   <= 1'b0;
            lo_byte <= '0;
            addr_q  <= '0;
            sh_go   <= 1'b0;
            sh_tx   <= '0;
            cs_act  <= 1'b0;
            fin     <= 1'b0;
            rd_word <= '0;
        end else begin
            sh_go <= 1'b0;
            fin   <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (launch) begin
                        addr_q  <= word_addr;
                        again   <= 1'b1;
                        gap_cnt <= '0;
                        state   <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (gap_cnt == GW'(CLK_DIV - 1)) begin
                        cs_act <= 1'b1;
                        sh_go  <= 1'b1;
                        sh_tx  <= again ? OP_STATUS : OP_READ;
                        state  <= again ? S_POLL_CMD : S_RD_CMD;
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                S_POLL_CMD: begin
                    if (sh_done) begin
                        sh_go <= 1'b1;
                        sh_tx <= 8'h00;
                        state <= S_POLL_STAT;
                    end
                end
                S_POLL_STAT: begin
                    if (sh_done) begin
                        cs_act  <= 1'b0;
                        again   <= sh_rx[0];
                        gap_cnt <= '0;
                        state   <= S_GAP;
                    end
                end
                S_RD_CMD: begin
                    if (sh_done) begin
                        sh_go <= 1'b1;
                        sh_tx <= byte_addr;
                        state <= S_RD_ADDR;
                    end
                end
                S_RD_ADDR: begin
                    if (sh_done) begin
                        sh_go <= 1'b1;
                        sh_tx <= 8'h00;
                        state <= S_RD_LO;
                    end
                end
                S_RD_LO: begin
                    if (sh_done) begin
                        lo_byte <= sh_rx;
                        sh_go   <= 1'b1;
                        sh_tx   <= 8'h00;
                        state   <= S_RD_HI;
                    end
                end
                S_RD_HI: begin
                    if (sh_done) begin
                        rd_word <= {sh_rx, lo_byte};
                        cs_act  <= 1'b0;
                        fin     <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign idle = (state == S_IDLE);
endmodule

// File: rtl/spi_port_arbiter.sv
// Module: spi_port_arbiter
// Owns the grant flag and selects which source drives the SPI pins.
// Assumes: the engine is only launched while grant is low; a pending start
// outranks a new software request.
module spi_port_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic eng_idle,
    input  logic start_pend,
    input  logic sw_sck,
    input  logic sw_cs,
    input  logic sw_mosi,
    input  logic eng_sck,
    input  logic eng_cs,
    input  logic eng_mosi,
    output logic grant,
    output logic pin_sck,
    output logic pin_cs_n,
    output logic pin_mosi
);
    // Grant: held while requested; newly given only to an idle, unclaimed port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= 1'b0;
        end else begin
            grant <= sw_req && (grant || (eng_idle && !start_pend));
        end
    end

    // Pin mux: software pins while granted, engine pins otherwise.
    always_comb begin
        if (grant) begin
            pin_sck  = sw_sck;
            pin_cs_n = ~sw_cs;
            pin_mosi = sw_mosi;
        end else begin
            pin_sck  = eng_sck;
            pin_cs_n = ~eng_cs;
            pin_mosi = eng_mosi;
        end
    end
endmodule

// File: rtl/spi_word_reader.sv
// Module: spi_word_reader (top)
// Request and pin registers plus the engine, shifter and arbiter.
// Assumes: CLK_DIV even and >= 2; WORDS a power of two no larger than 128.
module spi_word_reader
    import spi_rd_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int WORDS   = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_wr,
    input  logic [31:0] req_wdata,
    output logic [31:0] req_rdata,
    input  logic        bb_wr,
    input  logic [31:0] bb_wdata,
    output logic [31:0] bb_rdata,
    input  logic        ee_present,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    localparam int WORD_AW = $clog2(WORDS);
    localparam int AF_W    = REQ_AHI - REQ_ALO + 1;

    logic            start_q;
    logic            done_q;
    logic [AF_W-1:0] addr_q;
    logic [15:0]     data_q;
    logic            req_q;
    logic            sw_sck;
    logic            sw_cs;
    logic            sw_mosi;
    logic            grant;
    logic            launch;
    logic            seq_idle;
    logic            seq_fin;
    logic [15:0]     seq_word;
    logic            sh_go;
    logic [7:0]      sh_tx;
    logic            sh_done;
    logic [7:0]      sh_rx;
    logic            eng_sck;
    logic            eng_mosi;
    logic            eng_cs;
    logic            unused_wbits;

    assign unused_wbits = ^{req_wdata[31:16], req_wdata[REQ_DONE],
                            bb_wdata[31:7], bb_wdata[5:3]};

    assign launch = start_q && !grant && seq_idle;

    // Request register: capture result, self-clear start, accept idle writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (seq_fin) begin
                done_q <= 1'b1;
                data_q <= seq_word;
            end
            if (launch) begin
                start_q <= 1'b0;
            end
            if (req_wr && seq_idle) begin
                addr_q <= req_wdata[REQ_AHI:REQ_ALO];
                if (req_wdata[REQ_START]) begin
                    start_q <= 1'b1;
                    done_q  <= 1'b0;
                end
            end
        end
    end

    // Pin register: request always writable, pin bits only under grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            sw_sck  <= 1'b0;
            sw_cs   <= 1'b0;
            sw_mosi <= 1'b0;
        end else begin
            if (bb_wr) begin
                req_q <= bb_wdata[PIN_REQ];
            end
            if (!grant) begin
                sw_sck  <= 1'b0;
                sw_cs   <= 1'b0;
                sw_mosi <= 1'b0;
            end else if (bb_wr) begin
                sw_sck  <= bb_wdata[PIN_SCK];
                sw_cs   <= bb_wdata[PIN_CS];
                sw_mosi <= bb_wdata[PIN_MOSI];
            end
        end
    end

    assign req_rdata = {data_q, addr_q, done_q, start_q};
    assign bb_rdata  = {23'd0, ee_present, grant, req_q, 2'b00,
                        spi_miso, sw_mosi, sw_cs, sw_sck};

    spi_read_seq #(
        .CLK_DIV (CLK_DIV),
        .WORD_AW (WORD_AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .word_addr (addr_q[WORD_AW-1:0]),
        .sh_done   (sh_done),
        .sh_rx     (sh_rx),
        .sh_go     (sh_go),
        .sh_tx     (sh_tx),
        .cs_act    (eng_cs),
        .idle      (seq_idle),
        .fin       (seq_fin),
        .rd_word   (seq_word)
    );

    spi_byte_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (sh_go),
        .tx_byte (sh_tx),
        .miso    (spi_miso),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sck     (eng_sck),
        .mosi    (eng_mosi)
    );

    spi_port_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_req     (req_q),
        .eng_idle   (seq_idle),
        .start_pend (start_q),
        .sw_sck     (sw_sck),
        .sw_cs      (sw_cs),
        .sw_mosi    (sw_mosi),
        .eng_sck    (eng_sck),
        .eng_cs     (eng_cs),
        .eng_mosi   (eng_mosi),
        .grant      (grant),
        .pin_sck    (spi_sck),
        .pin_cs_n   (spi_cs_n),
        .pin_mosi   (spi_mosi)
    );
endmodule

// File: rtl/spi_word_reader_chk.sv
// Module: spi_word_reader_chk
// Property checker bound into spi_word_reader; observes pins and the
// signals passed between the engine, arbiter and register logic.
module spi_word_reader_chk #(
    parameter int CLK_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic grant,
    input logic eng_cs,
    input logic seq_idle,
    input logic pending,
    input logic done_flag,
    input logic req_wr,
    input logic req_start,
    input logic spi_sck,
    input logic spi_mosi,
    input logic spi_cs_n
);
    localparam int HW = $clog2(CLK_DIV + 1);

    logic [HW-1:0] hi_cnt;

    // Counts cycles the engine select has been released, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (eng_cs) begin
            hi_cnt <= '0;
        end else if (hi_cnt < HW'(CLK_DIV)) begin
            hi_cnt <= hi_cnt + HW'(1);
        end
    end

    // R1: idle engine without grant leaves select inactive
    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_idle && !grant) |-> spi_cs_n);

    // R2: an accepted start clears done and shows pending
    a_r2_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && req_start && seq_idle) |=> (!done_flag && pending));

    // R5: select released for at least one SPI period before each assertion
    a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_cs) |-> (hi_cnt >= HW'(CLK_DIV)));

    // R6: data out holds across rising clock edges in engine mode
    a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_sck) && !grant && !$past(grant)) |-> $stable(spi_mosi));

    // R7: engine never selects the device while software owns the port
    a_r7_grant_excl: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !eng_cs);

    // R9: a start pending under grant is not consumed
    a_r9_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && pending) |=> pending);
endmodule

bind spi_word_reader spi_word_reader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .eng_cs    (eng_cs),
    .seq_idle  (seq_idle),
    .pending   (start_q),
    .done_flag (done_q),
    .req_wr    (req_wr),
    .req_start (req_wdata[0]),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .spi_cs_n  (spi_cs_n)
);

// File: tb/spi_word_reader_tb.sv
// Bench for spi_word_reader: behavioural EEPROM model, vector table of
// fetches, then directed tests for reset, arbitration and corner cases.
module spi_word_reader_tb;
    localparam int CLK_DIV = 4;
    localparam int WORDS   = 64;

    // stimulus table: word address, busy polls, expected poll count
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{5,     0, 1},
        '{0,     2, 3},
        '{63,    1, 2},
        '{70,    0, 1},
        '{33,    3, 4},
        '{16383, 0, 1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] req_rdata;
    logic        bb_wr = 1'b0;
    logic [31:0] bb_wdata = '0;
    logic [31:0] bb_rdata;
    logic        ee_present = 1'b1;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso;

    always #5 clk = ~clk;

    spi_word_reader #(.CLK_DIV(CLK_DIV), .WORDS(WORDS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_wr(req_wr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .bb_wr(bb_wr), .bb_wdata(bb_wdata), .bb_rdata(bb_rdata),
        .ee_present(ee_present),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    int n_chk = 0;
    int n_err = 0;

    // ---------------- EEPROM model ----------------
    logic [15:0] image [WORDS];
    logic [7:0]  cmd = '0;
    logic [7:0]  abyte = '0;
    logic [7:0]  last_addr = '0;
    int          bitcnt = 0;
    int          n_polls = 0;
    int          n_reads = 0;
    int          poll_base = 0;
    int          busy_target = 0;
    logic        model_miso = 1'b0;
    logic        force_en = 1'b0;
    logic        force_val = 1'b0;

    assign spi_miso = force_en ? force_val : model_miso;

    // Model: sample command and address on rising clock under select.
    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (spi_sck && !spi_cs_n) begin
            if (bitcnt < 8) begin
                cmd <= {cmd[6:0], spi_mosi};
                if (bitcnt == 7 && {cmd[6:0], spi_mosi} == 8'h05) n_polls <= n_polls + 1;
                if (bitcnt == 7 && {cmd[6:0], spi_mosi} == 8'h03) n_reads <= n_reads + 1;
            end else if (bitcnt < 16 && cmd == 8'h03) begin
                abyte <= {abyte[6:0], spi_mosi};
                if (bitcnt == 15) last_addr <= {abyte[6:0], spi_mosi};
            end
            bitcnt <= bitcnt + 1;
        end else begin
            bitcnt <= 0;
            cmd    <= '0;
        end
    end

    // Model: drive response bits on falling clock.
    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (cmd == 8'h05 && bitcnt >= 8) begin
                model_miso <= ((n_polls - poll_base) <= busy_target) && (((bitcnt - 8) % 8) == 7);
            end else if (cmd == 8'h03 && bitcnt >= 16) begin
                int k;
                int b;
                logic [15:0] w;
                k = bitcnt - 16;
                b = (int'(abyte) + k / 8) % (2 * WORDS);
                w = image[b / 2];
                model_miso <= (b % 2 == 1) ? w[15 - (k % 8)] : w[7 - (k % 8)];
            end
        end
    end

    // ---------------- pin monitors (R5, R6) ----------------
    logic bb_mode = 1'b0;
    logic prev_sck = 1'b0;
    logic prev_mosi = 1'b0;
    logic prev_cs_n = 1'b1;
    int   hi_run = 0;
    int   gap_bad = 0;
    int   edge_bad = 0;

    always @(negedge clk) begin
        if (rst_n && !bb_mode) begin
            if (spi_sck && !prev_sck && spi_mosi !== prev_mosi) edge_bad <= edge_bad + 1;
            if (spi_cs_n && spi_sck) edge_bad <= edge_bad + 1;
            if (!spi_cs_n && prev_cs_n && hi_run < CLK_DIV) gap_bad <= gap_bad + 1;
            hi_run <= spi_cs_n ? hi_run + 1 : 0;
        end else begin
            hi_run <= 0;
        end
        prev_sck  <= spi_sck;
        prev_mosi <= spi_mosi;
        prev_cs_n <= spi_cs_n;
    end

    // ---------------- helpers ----------------
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    task automatic wr_req(input logic [31:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic wr_bb(input logic [31:0] d);
        @(negedge clk);
        bb_wr = 1'b1; bb_wdata = d;
        @(negedge clk);
        bb_wr = 1'b0;
    endtask

    task automatic wait_done();
        int t;
        t = 0;
        while (req_rdata[1] !== 1'b1 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) check("R3 done timeout", 32'd0, 32'd1);
    endtask

    function automatic logic [31:0] start_word(input int addr);
        logic [13:0] a;
        a = 14'(addr);
        return {16'd0, a, 2'b01};
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual running expected finished");
        summary();
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [15:0] s;
        int          rb;
        int          wa;
        s = '0;
        for (int i = 0; i < WORDS - 1; i++) begin
            image[i] = 16'(i * 16'h02F1 + 16'h0013);
            s = s + image[i];
        end
        image[WORDS - 1] = 16'hBABA - s;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 req_rdata", req_rdata, 32'd0);
        check("R1 pin bits", bb_rdata & 32'h0000_00F7, 32'd0);
        check("R1 cs_n", {31'd0, spi_cs_n}, 32'd1);
        check("R1 sck", {31'd0, spi_sck}, 32'd0);

        // table walk: R3, R4, R13
        for (int v = 0; v < NV; v++) begin
            busy_target = VEC[v][1];
            poll_base   = n_polls;
            rb          = n_reads;
            wa          = VEC[v][0] % WORDS;
            wr_req(start_word(VEC[v][0]));
            wait_done();
            check("R3 word", {16'd0, req_rdata[31:16]}, {16'd0, image[wa]});
            check("R3 start clear", {31'd0, req_rdata[0]}, 32'd0);
            check("R3 one read cmd", n_reads - rb, 32'd1);
            check("R4 poll count", n_polls - poll_base, VEC[v][2]);
            check("R13 byte address", {24'd0, last_addr}, 32'(2 * wa));
        end
        busy_target = 0;

        // R2: done clears on start, start self-clears next cycle
        poll_base = n_polls;
        wr_req(start_word(3));
        check("R2 done cleared", {31'd0, req_rdata[1]}, 32'd0);
        check("R2 start shown", {31'd0, req_rdata[0]}, 32'd1);
        @(negedge clk);
        check("R2 start self-clear", {31'd0, req_rdata[0]}, 32'd0);
        wait_done();
        check("R2 word", {16'd0, req_rdata[31:16]}, {16'd0, image[3]});

        // R11: write during fetch ignored
        poll_base = n_polls;
        rb = n_reads;
        wr_req(start_word(20));
        repeat (30) @(negedge clk);
        wr_req(start_word(40));
        wait_done();
        check("R11 word of first request", {16'd0, req_rdata[31:16]}, {16'd0, image[20]});
        check("R11 address kept", {18'd0, req_rdata[15:2]}, 32'd20);
        check("R11 single read", n_reads - rb, 32'd1);
        check("R11 no second start", {31'd0, req_rdata[0]}, 32'd0);

        // R8: pin writes without grant ignored
        bb_mode = 1'b1;
        wr_bb(32'h0000_0007);
        check("R8 pins ignored", bb_rdata & 32'h7, 32'd0);
        check("R8 cs_n unchanged", {31'd0, spi_cs_n}, 32'd1);
        check("R8 sck unchanged", {31'd0, spi_sck}, 32'd0);

        // R7: request then grant one cycle later
        wr_bb(32'h0000_0040);
        check("R7 grant not yet", {31'd0, bb_rdata[7]}, 32'd0);
        @(negedge clk);
        check("R7 grant given", {31'd0, bb_rdata[7]}, 32'd1);

        // R8: pins follow register while granted
        wr_bb(32'h0000_0047);
        check("R8 sck follows", {31'd0, spi_sck}, 32'd1);
        check("R8 cs_n follows", {31'd0, spi_cs_n}, 32'd0);
        check("R8 mosi follows", {31'd0, spi_mosi}, 32'd1);
        wr_bb(32'h0000_0040);

        // R12: data-in and presence visible
        force_en = 1'b1; force_val = 1'b1;
        @(negedge clk);
        check("R12 miso bit", {31'd0, bb_rdata[3]}, 32'd1);
        force_val = 1'b0;
        @(negedge clk);
        check("R12 miso low", {31'd0, bb_rdata[3]}, 32'd0);
        force_en = 1'b0;
        ee_present = 1'b0;
        @(negedge clk);
        check("R12 absent", {31'd0, bb_rdata[8]}, 32'd0);
        ee_present = 1'b1;
        @(negedge clk);
        check("R12 present", {31'd0, bb_rdata[8]}, 32'd1);

        // R9: start while granted stays pending
        rb = n_reads;
        wr_req(start_word(9));
        repeat (40) @(negedge clk);
        check("R9 still pending", {31'd0, req_rdata[0]}, 32'd1);
        check("R9 no transfer", n_reads - rb, 32'd0);
        check("R9 select idle", {31'd0, spi_cs_n}, 32'd1);
        wr_bb(32'h0000_0000);
        bb_mode = 1'b0;
        @(negedge clk);
        check("R7 grant dropped", {31'd0, bb_rdata[7]}, 32'd0);
        poll_base = n_polls;
        wait_done();
        check("R9 word after release", {16'd0, req_rdata[31:16]}, {16'd0, image[9]});

        // R10: start and request in the same cycle
        poll_base = n_polls;
        @(negedge clk);
        req_wr = 1'b1; req_wdata = start_word(12);
        bb_wr = 1'b1;  bb_wdata = 32'h0000_0040;
        @(negedge clk);
        req_wr = 1'b0; bb_wr = 1'b0;
        check("R10 pending", {31'd0, req_rdata[0]}, 32'd1);
        @(negedge clk);
        check("R10 engine took port", {31'd0, req_rdata[0]}, 32'd0);
        check("R10 grant withheld", {31'd0, bb_rdata[7]}, 32'd0);
        repeat (50) @(negedge clk);
        check("R10 grant still withheld", {31'd0, bb_rdata[7]}, 32'd0);
        wait_done();
        check("R10 word", {16'd0, req_rdata[31:16]}, {16'd0, image[12]});
        repeat (2) @(negedge clk);
        check("R10 grant after fetch", {31'd0, bb_rdata[7]}, 32'd1);
        bb_mode = 1'b1;
        wr_bb(32'h0000_0000);
        @(negedge clk);
        bb_mode = 1'b0;

        // R13: whole image sums to 0xBABA
        s = '0;
        for (int i = 0; i < WORDS; i++) begin
            poll_base = n_polls;
            wr_req(start_word(i));
            wait_done();
            s = s + req_rdata[31:16];
        end
        check("R13 image sum", {16'd0, s}, 32'h0000_BABA);

        // R5, R6: pin monitor results
        check("R5 select gap", gap_bad, 32'd0);
        check("R6 mode 0 edges", edge_bad, 32'd0);

        summary();
        $finish;
    end
endmodule